// File: doc/BRIEF.md
# Frame Delay Timer with Trigger

This block times the gap between the end of a reader's modulation pause and the start of a card emulator's synchronous reply. It runs a 16-bit up-counter that advances once for each recovered carrier cycle, marked by a one-cycle enable. The counter is not driven by the system clock. A falling edge on the demodulated-data input is synchronised and then restarts the count from zero.

Three compare values shape the reply. When the count reaches compare A, a waveform output goes high, and that rising edge starts the transmit frame of a serial transmitter. Compare B marks the end of the received frame and affects only a status flag. Compare C drives the waveform low and freezes the counter until the next restart.

Software writes the compare values, a control word and an interrupt mask through a simple write port. It sees four sticky event flags and a level interrupt. A pulse on a read strobe clears the flags.

Top module: `fdt_timer`

## Requirements
- R1: While the timer is running and the clock-enable bit is 1, the count rises by exactly one on every clock edge where `carrier_en` is 1. With `carrier_en` low or the clock-enable bit 0, the count holds.
- R2: `trig_in` passes through two synchroniser flops. On the third clock edge after it falls, the count becomes 0, the timer runs, `wave_out` goes low and flag bit 0 is set, whatever `carrier_en` is. A rising edge of `trig_in` does nothing.
- R3: On a counting tick where the count equals compare A, flag bit 1 is set and `wave_out` is high after that edge.
- R4: On a counting tick where the count equals compare C, flag bit 3 is set, `wave_out` goes low and the count stays at that value. If A and C are equal, low wins.
- R5: Once stopped by compare C, the count, `wave_out` and the flags stay unchanged on later carrier ticks until a trigger or a software start.
- R6: On a counting tick where the count equals compare B, flag bit 2 is set. `wave_out` does not change.
- R7: After reset: compare A = 128, B = 256, C = 0xFFFF, clock-enable 0, interrupt mask 0, count 0, timer idle, `wave_out` 0, flags 0, `irq` 0.
- R8: Flags are sticky, with bit 0 = trigger, 1 = A, 2 = B, 3 = C. A `rd_clr` pulse clears them on that edge, and an event in the same cycle still sets its bit.
- R9: `irq` is high exactly when some flag bit is set and the mask bit in the same position is 1.
- R10: A control write sets clock-enable from data bit 0. If data bit 1 is 1, the same edge zeroes the count and starts the timer without touching `wave_out` or flag bit 0.
- R11: Write addresses: 0 compare A, 1 compare B, 2 compare C, 3 control, 4 interrupt mask (data bits 3:0). Each write takes effect on the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_en | input | 1 | One pulse per carrier cycle |
| trig_in | input | 1 | Asynchronous demodulated data; falling edge restarts |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_clr | input | 1 | Status read strobe, clears flags |
| count | output | 16 | Current counter value |
| wave_out | output | 1 | Transmit-frame start waveform |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, software starts and flag clears are visible one clock edge after the strobe. A trigger lands on the third edge after `trig_in` falls. So the bench drives every input on the falling clock edge, counts the rising edges each action needs, and samples on the next falling edge. For compare matches, the bench holds `carrier_en` high for an exact number of edges. The expected count, waveform level and flags then follow from which counter values were visited on those ticks. `irq` follows the flags in the same cycle, so it is sampled together with them.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    localparam int FLAG_N = 4;

    // flag bit positions, also used by the interrupt mask
    localparam int FLG_TRIG = 0;
    localparam int FLG_A    = 1;
    localparam int FLG_B    = 2;
    localparam int FLG_C    = 3;

    // control word bits
    localparam int CTRL_CLKEN = 0;
    localparam int CTRL_START = 1;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CMP_A = 3'd0,
        ADDR_CMP_B = 3'd1,
        ADDR_CMP_C = 3'd2,
        ADDR_CTRL  = 3'd3,
        ADDR_IMASK = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/fdt_trig_sync.sv
module fdt_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_fall
);
    localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] chain;
        logic         prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[S-2:0], trig_in};
        s_d.prev  = s_q.chain[S-1];
        trig_fall = s_q.prev & ~s_q.chain[S-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fdt_regs.sv
module fdt_regs
    import fdt_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int unsigned A_RST = 128,
    parameter int unsigned B_RST = 256,
    parameter int unsigned C_RST = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic [CNT_W-1:0]  cmp_c,
    output logic              clken,
    output logic [FLAG_N-1:0] imask,
    output logic              sw_start
);
    typedef struct packed {
        logic [CNT_W-1:0]  a;
        logic [CNT_W-1:0]  b;
        logic [CNT_W-1:0]  c;
        logic              clken;
        logic [FLAG_N-1:0] imask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        sw_start = 1'b0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CMP_A: r_d.a = wr_data;
                ADDR_CMP_B: r_d.b = wr_data;
                ADDR_CMP_C: r_d.c = wr_data;
                ADDR_CTRL: begin
                    r_d.clken = wr_data[CTRL_CLKEN];
                    sw_start  = wr_data[CTRL_START];
                end
                ADDR_IMASK: r_d.imask = wr_data[FLAG_N-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.a     <= CNT_W'(A_RST);
            r_q.b     <= CNT_W'(B_RST);
            r_q.c     <= CNT_W'(C_RST);
            r_q.clken <= 1'b0;
            r_q.imask <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmp_a = r_q.a;
    assign cmp_b = r_q.b;
    assign cmp_c = r_q.c;
    assign clken = r_q.clken;
    assign imask = r_q.imask;
endmodule

// File: rtl/fdt_core.sv
module fdt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_en,
    input  logic             clken,
    input  logic             trig_fall,
    input  logic             sw_start,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             wave,
    output logic             hit_a,
    output logic             hit_b,
    output logic             hit_c
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             wave;
    } core_t;

    core_t c_d, c_q;
    logic  tick;

    always_comb begin
        c_d   = c_q;
        hit_a = 1'b0;
        hit_b = 1'b0;
        hit_c = 1'b0;
        tick  = c_q.running & clken & carrier_en;
        if (trig_fall || sw_start) begin
            // a restart beats any compare in the same cycle
            c_d.count   = '0;
            c_d.running = 1'b1;
            if (trig_fall) c_d.wave = 1'b0;
        end else if (tick) begin
            hit_a = (c_q.count == cmp_a);
            hit_b = (c_q.count == cmp_b);
            hit_c = (c_q.count == cmp_c);
            if (hit_a) c_d.wave = 1'b1;
            if (hit_c) begin
                c_d.wave    = 1'b0;   // clear wins over set
                c_d.running = 1'b0;   // freeze, no reload
            end else begin
                c_d.count = c_q.count + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count   = c_q.count;
    assign running = c_q.running;
    assign wave    = c_q.wave;
endmodule

// File: rtl/fdt_status.sv
module fdt_status
    import fdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] events,
    input  logic              rd_clr,
    input  logic [FLAG_N-1:0] imask,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    typedef struct packed {
        logic [FLAG_N-1:0] flags;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (rd_clr ? '0 : st_q.flags) | events;
        irq        = |(st_q.flags & imask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/fdt_timer.sv
module fdt_timer
    import fdt_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int unsigned A_RST = 128,
    parameter int unsigned B_RST = 256,
    parameter int unsigned C_RST = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_en,
    input  logic              trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_clr,
    output logic [CNT_W-1:0]  count,
    output logic              wave_out,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    logic              trig_fall;
    logic              sw_start;
    logic              running;
    logic              clken;
    logic [CNT_W-1:0]  cmp_a, cmp_b, cmp_c;
    logic [FLAG_N-1:0] imask;
    logic              hit_a, hit_b, hit_c;
    logic [FLAG_N-1:0] events;

    fdt_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_fall (trig_fall)
    );

    fdt_regs #(
        .CNT_W (CNT_W),
        .A_RST (A_RST),
        .B_RST (B_RST),
        .C_RST (C_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .cmp_c    (cmp_c),
        .clken    (clken),
        .imask    (imask),
        .sw_start (sw_start)
    );

    fdt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_en (carrier_en),
        .clken      (clken),
        .trig_fall  (trig_fall),
        .sw_start   (sw_start),
        .cmp_a      (cmp_a),
        .cmp_b      (cmp_b),
        .cmp_c      (cmp_c),
        .count      (count),
        .running    (running),
        .wave       (wave_out),
        .hit_a      (hit_a),
        .hit_b      (hit_b),
        .hit_c      (hit_c)
    );

    always_comb begin
        events           = '0;
        events[FLG_TRIG] = trig_fall;
        events[FLG_A]    = hit_a;
        events[FLG_B]    = hit_b;
        events[FLG_C]    = hit_c;
    end

    fdt_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .rd_clr (rd_clr),
        .imask  (imask),
        .flags  (flags),
        .irq    (irq)
    );
endmodule

// File: rtl/fdt_timer_chk.sv
module fdt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             carrier_en,
    input logic             rd_clr,
    input logic             trig_fall,
    input logic             sw_start,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             wave_out,
    input logic [3:0]       flags,
    input logic             irq
);
    // R2
    trig_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fall |=> (count == '0) && !wave_out && flags[0] && running);

    // R1
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_en && !trig_fall && !sw_start) |=> $stable(count));

    // R1
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_fall && !sw_start) |=>
            (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !trig_fall && !sw_start) |=> $stable(count) && $stable(wave_out));

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((flags & $past(flags)) == $past(flags)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 4'b0000) |-> !irq);
endmodule

bind fdt_timer fdt_timer_chk #(.CNT_W(CNT_W)) u_fdt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_en (carrier_en),
    .rd_clr     (rd_clr),
    .trig_fall  (trig_fall),
    .sw_start   (sw_start),
    .running    (running),
    .count      (count),
    .wave_out   (wave_out),
    .flags      (flags),
    .irq        (irq)
);

// File: tb/test_fdt_timer.sv
`timescale 1ns/1ps
module test_fdt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        carrier_en = 1'b0;
    logic        trig_in = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_clr = 1'b0;
    logic [15:0] count;
    logic        wave_out;
    logic [3:0]  flags;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fdt_timer i_fdt_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_en (carrier_en),
        .trig_in    (trig_in),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_clr     (rd_clr),
        .count      (count),
        .wave_out   (wave_out),
        .flags      (flags),
        .irq        (irq)
    );

    typedef struct packed {
        logic [15:0] a, b, c, ticks, exp_cnt;
        logic        exp_wave;
        logic [3:0]  exp_flags;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd5,  16'd10,  16'd20,    16'd8,  16'd8,  1'b1, 4'h3},  // R3 A only
        '{16'd5,  16'd10,  16'd20,    16'd15, 16'd15, 1'b1, 4'h7},  // R6 B keeps wave high
        '{16'd12, 16'd3,   16'd6,     16'd10, 16'd6,  1'b0, 4'hD},  // R4 stop before A
        '{16'd4,  16'd4,   16'd4,     16'd5,  16'd4,  1'b0, 4'hF},  // R4 C beats A
        '{16'd0,  16'd100, 16'hFFFF,  16'd1,  16'd1,  1'b1, 4'h3},  // R3 A at zero
        '{16'd5,  16'd10,  16'd20,    16'd30, 16'd20, 1'b0, 4'hF}   // R4 stop at C
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_clear();
        rd_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_clr = 1'b0;
    endtask

    task automatic do_trigger();
        carrier_en = 1'b0;
        trig_in = 1'b1;
        repeat (4) @(negedge clk);
        trig_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        carrier_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        carrier_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        chk("R7", "count", count, 0);
        chk("R7", "wave", wave_out, 0);
        chk("R7", "flags", flags, 0);
        chk("R7", "irq", irq, 0);

        // R7 defaults A=128 B=256 C=FFFF, R11 control address 3
        wr(3'd3, 16'h0001);
        do_trigger();
        chk("R2", "count after trigger", count, 0);
        chk("R2", "trigger flag", flags, 4'h1);
        ticks(257);
        chk("R7", "count default run", count, 257);
        chk("R7", "wave after default A", wave_out, 1);
        chk("R7", "flags default A,B", flags, 4'h7);

        // R2 trigger clears wave and restarts
        do_trigger();
        chk("R2", "count restart", count, 0);
        chk("R2", "wave cleared", wave_out, 0);

        // R1 no carrier ticks: hold
        repeat (5) @(negedge clk);
        chk("R1", "hold without carrier", count, 0);
        ticks(3);
        chk("R1", "three ticks", count, 3);

        // R10 clock-enable off gates counting
        wr(3'd3, 16'h0000);
        ticks(4);
        chk("R10", "clken off hold", count, 3);
        wr(3'd3, 16'h0001);

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VECS[i].a);
            wr(3'd1, VECS[i].b);
            wr(3'd2, VECS[i].c);
            rd_clear();
            do_trigger();
            ticks(int'(VECS[i].ticks));
            chk("R3/R4/R6 vec", "count", count, int'(VECS[i].exp_cnt));
            chk("R3/R4/R6 vec", "wave", wave_out, int'(VECS[i].exp_wave));
            chk("R8 vec", "flags", flags, int'(VECS[i].exp_flags));
        end

        // R5 stopped at C=20: further ticks change nothing
        rd_clear();
        chk("R8", "flags after clear", flags, 0);
        ticks(10);
        chk("R5", "stopped count", count, 20);
        chk("R5", "stopped flags", flags, 0);

        // R2 rising trigger edge is ignored
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", "rising edge count", count, 20);
        chk("R2", "rising edge flags", flags, 0);

        // R10 software start
        wr(3'd3, 16'h0003);
        chk("R10", "start count", count, 0);
        chk("R10", "start flags", flags, 0);
        ticks(6);
        chk("R10", "count after start", count, 6);
        chk("R3", "wave after start", wave_out, 1);
        chk("R10", "flags after start", flags, 4'h2);

        // R9 interrupt masking, R11 mask address 4
        wr(3'd4, 16'h0004);
        chk("R9", "masked irq", irq, 0);
        wr(3'd4, 16'h0002);
        chk("R9", "enabled irq", irq, 1);
        rd_clear();
        chk("R8", "flags cleared", flags, 0);
        chk("R9", "irq after clear", irq, 0);

        summary();
        $finish;
    end
endmodule